// File: doc/BRIEF.md
# Masked I/O Chip-Select Decoder

This block watches the I/O address of the expansion bus and produces chip selects for peripherals that sit behind general-purpose pins. It contains a set of independent decoders, two by default. Each one holds a 16-bit base address, taken as a low byte and a high byte. The eight lowest address bits can be excluded from the comparison one by one. Address bit 10 can be excluded as well, so that a parallel port's extended register block at base+400h decodes together with its primary block.

A matching decoder pulls an active-low select onto one of eight pins, chosen by a 3-bit field. The select is asserted only during a real I/O read or write that is not a DMA cycle. Each pin also reports whether some enabled decoder owns it, so that the surrounding pin logic knows to give up control. A matching decoder can also ask for fast bus timing, and a global bit asks for fast timing on every cycle. That request is registered and presented one clock later.

Top module: `io_cs_decoder`

## Requirements
- R1: With no bits excluded, a decoder hits only when all 16 address bits equal its base (`{base_hi, base_lo}`). A hit drives the selected pin's `pin_cs_n` low in the same cycle, combinationally.
- R2: A 1 in bit i (i = 0..7) of a decoder's `mask` removes address bit i from the comparison. Address bits 8..15 are always compared, apart from the rule in R3. Base 3F8h with mask 07h therefore hits 3F8h..3FFh and misses 3F7h and 13F8h.
- R3: When a decoder's `mirror_ign` bit is 1, address bit 10 is also left out of the comparison. Base 378h with mask 07h then hits both 378h..37Fh and 778h..77Fh, but still misses B78h. With the bit at 0, 778h misses.
- R4: A select is asserted only while `aen` is 0 and at least one of `ior_n` or `iow_n` is 0. Otherwise every `pin_cs_n` bit is 1.
- R5: A decoder whose enable bit is 0 claims no pin, whatever address is applied: its pins show `pin_ovr` = 0 and `pin_cs_n` = 1.
- R6: The control field `dec_ctrl` gives each decoder k one nibble. Bit 4k+3 is the enable and bits 4k+2..4k are the pin number, where 0..7 select pins 0..7. Decoder 0 therefore uses bit 3 and bits 2:0, and decoder 1 uses bit 7 and bits 6:4.
- R7: `pin_ovr[p]` is 1 exactly when at least one enabled decoder selects pin p. It does not depend on the address or the strobes. A pin whose `pin_cs_n` is low always has `pin_ovr` high.
- R8: When several enabled decoders select the same pin, that pin's select is low whenever any one of them hits.
- R9: `fast_req` rises on the clock edge after a cycle in which a decoder with its `fast_en` bit at 1 hits. Hits on decoders whose `fast_en` is 0 do not raise it.
- R10: While `fast_all` is 1, `fast_req` is 1 on the following clock edge, with or without a bus access.
- R11: While `rst_n` is 0, `fast_req` is 0 after each clock edge. Reset has no effect on the combinational select outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the fast-mode request register |
| rst_n | input | 1 | Synchronous active-low reset |
| io_addr | input | 16 | Bus I/O address |
| ior_n | input | 1 | I/O read strobe, active low |
| iow_n | input | 1 | I/O write strobe, active low |
| aen | input | 1 | DMA address enable; high blocks all selects |
| dec_ctrl | input | 4*NUM_DEC | Per-decoder enable and pin number, one nibble each |
| base_lo | input | NUM_DEC x 8 | Low byte of each decoder's base |
| base_hi | input | NUM_DEC x 8 | High byte of each decoder's base |
| mask | input | NUM_DEC x 8 | Per-decoder ignore bits for address bits 7..0 |
| mirror_ign | input | NUM_DEC | Per-decoder: ignore address bit 10 |
| fast_en | input | NUM_DEC | Per-decoder: a hit requests fast timing |
| fast_all | input | 1 | Request fast timing on every cycle |
| pin_cs_n | output | 8 | Active-low chip select per pin |
| pin_ovr | output | 8 | Per pin: an enabled decoder owns it |
| fast_req | output | 1 | Registered fast-timing request |

## Verification
The address patterns are chosen to bracket each range at both ends and to differ from the base in only one bit. That bit lies inside the mask, outside it in the upper byte, at bit 10, or at bit 11. Together they separate correct masking from an off-by-one mask width and from ignoring the wrong mirror bit. Strobe and AEN combinations are applied against a matching address, so a select driven from address alone is exposed. Two decoders are aimed at different pins and at the same pin, which tells correct steering and combining apart from a decoder leaking onto a neighbour's pin. Fast-request checks use a decoder with fast timing enabled and one without, and distinguish a registered request from a combinational one.

// File: rtl/io_cs_decoder_pkg.sv
`timescale 1ns/1ps
// Package: shared widths and the per-decoder configuration record.
// Assumes an I/O space of 16 address bits and a bank of eight pins.
package io_cs_decoder_pkg;
    localparam int CS_ADDR_W = 16;
    localparam int CS_MASK_W = 8;
    localparam int CS_PINS   = 8;
    localparam int CS_SEL_W  = $clog2(CS_PINS);
    localparam int CS_CTRL_W = CS_SEL_W + 1;

    typedef struct packed {
        logic [CS_ADDR_W-1:0] base;
        logic [CS_MASK_W-1:0] ign;
        logic                 mirror;
        logic                 en;
        logic [CS_SEL_W-1:0]  sel;
    } dec_cfg_t;
endpackage

// File: rtl/io_cs_match.sv
`timescale 1ns/1ps
// io_cs_match: compares one decoder's base against the bus address.
// Low bits may be excluded one by one and one mirror bit may be excluded as a whole.
// Assumes MIRROR_BIT lies above the mask field. The output is combinational.
module io_cs_match
    import io_cs_decoder_pkg::*;
#(
    parameter int ADDR_W     = CS_ADDR_W,
    parameter int MASK_W     = CS_MASK_W,
    parameter int MIRROR_BIT = 10
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] base,
    input  logic [MASK_W-1:0] ign,
    input  logic              mirror,
    input  logic              enable,
    input  logic              access,
    output logic              hit
);
    logic [ADDR_W-1:0] care;
    logic              same;

    // Build the set of address bits that take part in the comparison.
    always_comb begin
        care = '1;
        care[MASK_W-1:0] = ~ign;
        if (mirror) begin
            care[MIRROR_BIT] = 1'b0;
        end
    end

    // Compare the bits that take part, then qualify with enable and a valid access.
    always_comb begin
        same = (((addr ^ base) & care) == '0);
        hit  = enable & access & same;
    end
endmodule

// File: rtl/io_cs_steer.sv
`timescale 1ns/1ps
// io_cs_steer: routes one decoder's hit onto the pin chosen by its selector.
// Produces a per-pin ownership vector and a per-pin active-low select.
// Assumes PINS <= 2**SEL_W.
module io_cs_steer
    import io_cs_decoder_pkg::*;
#(
    parameter int PINS  = CS_PINS,
    parameter int SEL_W = CS_SEL_W
) (
    input  logic             enable,
    input  logic [SEL_W-1:0] sel,
    input  logic             hit,
    output logic [PINS-1:0]  own,
    output logic [PINS-1:0]  cs_n
);
    // Decode the selector into a one-hot ownership vector, gated by enable.
    always_comb begin
        for (int p = 0; p < PINS; p++) begin
            own[p] = enable && (sel == SEL_W'(p));
        end
    end

    // Drive the select low on the owned pin only while the decoder hits.
    always_comb begin
        cs_n = ~(own & {PINS{hit}});
    end
endmodule

// File: rtl/io_cs_fast.sv
`timescale 1ns/1ps
// io_cs_fast: registers the fast-timing request.
// A request comes from the global bit or from a hit on a decoder with fast timing enabled.
// Synchronous active-low reset clears the request.
module io_cs_fast #(
    parameter int NUM_DEC = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fast_all,
    input  logic [NUM_DEC-1:0] hits,
    input  logic [NUM_DEC-1:0] fast_en,
    output logic               fast_req
);
    logic req_d;

    // Combine the global request with the qualified per-decoder hits.
    always_comb begin
        req_d = fast_all | (|(hits & fast_en));
    end

    // Hold the request for the next bus clock; clear it in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fast_req <= 1'b0;
        end else begin
            fast_req <= req_d;
        end
    end
endmodule

// File: rtl/io_cs_decoder.sv
`timescale 1ns/1ps
// io_cs_decoder: a bank of NUM_DEC masked I/O decoders steering
// active-low selects onto a bank of pins.
// Assumes a bus access is valid while AEN is low and a strobe is low.
// The selects are combinational; the fast request is registered.
module io_cs_decoder
    import io_cs_decoder_pkg::*;
#(
    parameter int NUM_DEC    = 2,
    parameter int MIRROR_BIT = 10
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [CS_ADDR_W-1:0]         io_addr,
    input  logic                         ior_n,
    input  logic                         iow_n,
    input  logic                         aen,
    input  logic [NUM_DEC*CS_CTRL_W-1:0] dec_ctrl,
    input  logic [NUM_DEC-1:0][7:0]      base_lo,
    input  logic [NUM_DEC-1:0][7:0]      base_hi,
    input  logic [NUM_DEC-1:0][CS_MASK_W-1:0] mask,
    input  logic [NUM_DEC-1:0]           mirror_ign,
    input  logic [NUM_DEC-1:0]           fast_en,
    input  logic                         fast_all,
    output logic [CS_PINS-1:0]           pin_cs_n,
    output logic [CS_PINS-1:0]           pin_ovr,
    output logic                         fast_req
);
    logic                            access;
    dec_cfg_t [NUM_DEC-1:0]          cfg;
    logic [NUM_DEC-1:0]              hits;
    logic [NUM_DEC-1:0][CS_PINS-1:0] dec_own;
    logic [NUM_DEC-1:0][CS_PINS-1:0] dec_csn;

    // A valid access needs a non-DMA cycle with a read or write strobe.
    always_comb begin
        access = ~aen & (~ior_n | ~iow_n);
    end

    for (genvar k = 0; k < NUM_DEC; k++) begin : g_dec
        // Unpack the decoder's fields into its configuration record.
        always_comb begin
            cfg[k].base   = {base_hi[k], base_lo[k]};
            cfg[k].ign    = mask[k];
            cfg[k].mirror = mirror_ign[k];
            cfg[k].en     = dec_ctrl[k*CS_CTRL_W + CS_SEL_W];
            cfg[k].sel    = dec_ctrl[k*CS_CTRL_W +: CS_SEL_W];
        end

        io_cs_match #(
            .ADDR_W     (CS_ADDR_W),
            .MASK_W     (CS_MASK_W),
            .MIRROR_BIT (MIRROR_BIT)
        ) u_match (
            .addr   (io_addr),
            .base   (cfg[k].base),
            .ign    (cfg[k].ign),
            .mirror (cfg[k].mirror),
            .enable (cfg[k].en),
            .access (access),
            .hit    (hits[k])
        );

        io_cs_steer #(
            .PINS  (CS_PINS),
            .SEL_W (CS_SEL_W)
        ) u_steer (
            .enable (cfg[k].en),
            .sel    (cfg[k].sel),
            .hit    (hits[k]),
            .own    (dec_own[k]),
            .cs_n   (dec_csn[k])
        );
    end

    // Merge all decoders: ownership is ORed and active-low selects are ANDed.
    always_comb begin
        pin_ovr  = '0;
        pin_cs_n = '1;
        for (int k = 0; k < NUM_DEC; k++) begin
            pin_ovr  = pin_ovr | dec_own[k];
            pin_cs_n = pin_cs_n & dec_csn[k];
        end
    end

    io_cs_fast #(
        .NUM_DEC (NUM_DEC)
    ) u_fast (
        .clk      (clk),
        .rst_n    (rst_n),
        .fast_all (fast_all),
        .hits     (hits),
        .fast_en  (fast_en),
        .fast_req (fast_req)
    );
endmodule

// File: rtl/io_cs_decoder_chk.sv
`timescale 1ns/1ps
// io_cs_decoder_chk: port-level properties of the decoder bank, bound into the top.
module io_cs_decoder_chk
    import io_cs_decoder_pkg::*;
#(
    parameter int NUM_DEC = 2
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         ior_n,
    input logic                         iow_n,
    input logic                         aen,
    input logic [NUM_DEC*CS_CTRL_W-1:0] dec_ctrl,
    input logic                         fast_all,
    input logic [CS_PINS-1:0]           pin_cs_n,
    input logic [CS_PINS-1:0]           pin_ovr,
    input logic                         fast_req
);
    logic any_en;

    // Collect the enable bits of all decoders.
    always_comb begin
        any_en = 1'b0;
        for (int k = 0; k < NUM_DEC; k++) begin
            any_en = any_en | dec_ctrl[k*CS_CTRL_W + CS_SEL_W];
        end
    end

    a_r4_dma_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        aen |-> (&pin_cs_n));

    a_r4_idle_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (ior_n && iow_n) |-> (&pin_cs_n));

    a_r5_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !any_en |-> (pin_ovr == '0 && (&pin_cs_n)));

    a_r7_select_owned: assert property (@(posedge clk) disable iff (!rst_n)
        ((~pin_cs_n & ~pin_ovr) == '0));

    a_r10_global_fast: assert property (@(posedge clk) disable iff (!rst_n)
        fast_all |=> fast_req);

    a_r9_no_spurious_fast: assert property (@(posedge clk) disable iff (!rst_n)
        (!fast_all && (&pin_cs_n)) |=> !fast_req);

    a_r11_reset_clears: assert property (@(posedge clk)
        !rst_n |=> !fast_req);
endmodule

bind io_cs_decoder io_cs_decoder_chk #(.NUM_DEC(NUM_DEC)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ior_n    (ior_n),
    .iow_n    (iow_n),
    .aen      (aen),
    .dec_ctrl (dec_ctrl),
    .fast_all (fast_all),
    .pin_cs_n (pin_cs_n),
    .pin_ovr  (pin_ovr),
    .fast_req (fast_req)
);

// File: tb/io_cs_decoder_test.sv
`timescale 1ns/1ps
module io_cs_decoder_test;
    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [15:0]      io_addr = '0;
    logic             ior_n = 1'b1;
    logic             iow_n = 1'b1;
    logic             aen = 1'b0;
    logic [7:0]       dec_ctrl = '0;
    logic [1:0][7:0]  base_lo = '0;
    logic [1:0][7:0]  base_hi = '0;
    logic [1:0][7:0]  mask = '0;
    logic [1:0]       mirror_ign = '0;
    logic [1:0]       fast_en = '0;
    logic             fast_all = 1'b0;
    logic [7:0]       pin_cs_n;
    logic [7:0]       pin_ovr;
    logic             fast_req;

    int vectors = 0;
    int misses  = 0;

    always #2 clk = ~clk;

    io_cs_decoder uut (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .ior_n(ior_n), .iow_n(iow_n),
        .aen(aen), .dec_ctrl(dec_ctrl), .base_lo(base_lo), .base_hi(base_hi),
        .mask(mask), .mirror_ign(mirror_ign), .fast_en(fast_en), .fast_all(fast_all),
        .pin_cs_n(pin_cs_n), .pin_ovr(pin_ovr), .fast_req(fast_req)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        vectors++;
        if (act !== exp) begin
            misses++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic set_dec(input int k, input logic [15:0] b, input logic [7:0] m,
                           input logic mir, input logic fst);
        base_lo[k]    = b[7:0];
        base_hi[k]    = b[15:8];
        mask[k]       = m;
        mirror_ign[k] = mir;
        fast_en[k]    = fst;
    endtask

    // Drive a bus access between edges and let the combinational outputs settle.
    task automatic access(input logic [15:0] a, input logic r_n, input logic w_n, input logic dma);
        @(negedge clk);
        io_addr = a; ior_n = r_n; iow_n = w_n; aen = dma;
        #1;
    endtask

    task automatic t_reset;
        @(posedge clk); #1;
        check("R11 fast_req in reset", {7'd0, fast_req}, 8'h00);
        check("R5 no override at reset", pin_ovr, 8'h00);
        check("R5 no select at reset", pin_cs_n, 8'hFF);
        @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic t_exact;
        set_dec(0, 16'h0300, 8'h00, 1'b0, 1'b0);
        dec_ctrl = 8'h0D;                       // decoder 0 enabled, pin 5
        access(16'h0300, 1'b0, 1'b1, 1'b0);
        check("R1 exact hit pin5", pin_cs_n, 8'hDF);
        check("R6 decoder0 owns pin5", pin_ovr, 8'h20);
        access(16'h0301, 1'b0, 1'b1, 1'b0);
        check("R1 off by one misses", pin_cs_n, 8'hFF);
        access(16'h2300, 1'b0, 1'b1, 1'b0);
        check("R1 high bit differs misses", pin_cs_n, 8'hFF);
    endtask

    task automatic t_mask;
        set_dec(0, 16'h03F8, 8'h07, 1'b0, 1'b0);
        dec_ctrl = 8'h0D;
        access(16'h03F8, 1'b0, 1'b1, 1'b0);
        check("R2 range low end", pin_cs_n, 8'hDF);
        access(16'h03FF, 1'b0, 1'b1, 1'b0);
        check("R2 range high end", pin_cs_n, 8'hDF);
        access(16'h03F7, 1'b0, 1'b1, 1'b0);
        check("R2 below range", pin_cs_n, 8'hFF);
        access(16'h13F8, 1'b0, 1'b1, 1'b0);
        check("R2 bit12 still compared", pin_cs_n, 8'hFF);
        access(16'h02F8, 1'b0, 1'b1, 1'b0);
        check("R2 bit8 still compared", pin_cs_n, 8'hFF);
    endtask

    task automatic t_mirror;
        set_dec(0, 16'h0378, 8'h07, 1'b1, 1'b0);
        dec_ctrl = 8'h0D;
        access(16'h0778, 1'b0, 1'b1, 1'b0);
        check("R3 mirror range hit", pin_cs_n, 8'hDF);
        access(16'h037C, 1'b0, 1'b1, 1'b0);
        check("R3 primary range hit", pin_cs_n, 8'hDF);
        access(16'h0B78, 1'b0, 1'b1, 1'b0);
        check("R3 bit11 still compared", pin_cs_n, 8'hFF);
        mirror_ign[0] = 1'b0;
        access(16'h0778, 1'b0, 1'b1, 1'b0);
        check("R3 mirror off misses", pin_cs_n, 8'hFF);
    endtask

    task automatic t_strobe;
        set_dec(0, 16'h0300, 8'h00, 1'b0, 1'b0);
        dec_ctrl = 8'h0D;
        access(16'h0300, 1'b0, 1'b1, 1'b1);
        check("R4 aen blocks read", pin_cs_n, 8'hFF);
        access(16'h0300, 1'b1, 1'b1, 1'b0);
        check("R4 no strobe no select", pin_cs_n, 8'hFF);
        check("R7 ownership without strobe", pin_ovr, 8'h20);
        access(16'h0300, 1'b1, 1'b0, 1'b0);
        check("R4 write strobe selects", pin_cs_n, 8'hDF);
    endtask

    task automatic t_steer;
        set_dec(0, 16'h0300, 8'h00, 1'b0, 1'b0);
        set_dec(1, 16'h02E8, 8'h00, 1'b0, 1'b0);
        dec_ctrl = 8'hAD;                       // decoder1 pin 2, decoder0 pin 5
        access(16'h02E8, 1'b1, 1'b0, 1'b0);
        check("R6 decoder1 on pin2", pin_cs_n, 8'hFB);
        check("R7 two owned pins", pin_ovr, 8'h24);
        access(16'h0300, 1'b1, 1'b0, 1'b0);
        check("R6 decoder0 still on pin5", pin_cs_n, 8'hDF);
    endtask

    task automatic t_disable;
        set_dec(0, 16'h0300, 8'h00, 1'b0, 1'b0);
        dec_ctrl = 8'h05;                       // pin 5 chosen but not enabled
        access(16'h0300, 1'b0, 1'b1, 1'b0);
        check("R5 disabled no select", pin_cs_n, 8'hFF);
        check("R5 disabled no override", pin_ovr, 8'h00);
    endtask

    task automatic t_share;
        set_dec(0, 16'h0100, 8'h00, 1'b0, 1'b0);
        set_dec(1, 16'h0200, 8'h00, 1'b0, 1'b0);
        dec_ctrl = 8'hBB;                       // both on pin 3
        access(16'h0100, 1'b0, 1'b1, 1'b0);
        check("R8 shared pin via decoder0", pin_cs_n, 8'hF7);
        access(16'h0200, 1'b0, 1'b1, 1'b0);
        check("R8 shared pin via decoder1", pin_cs_n, 8'hF7);
        access(16'h0300, 1'b0, 1'b1, 1'b0);
        check("R8 shared pin idle", pin_cs_n, 8'hFF);
        check("R7 shared ownership", pin_ovr, 8'h08);
    endtask

    task automatic t_fast;
        set_dec(0, 16'h0100, 8'h00, 1'b0, 1'b1);
        set_dec(1, 16'h0200, 8'h00, 1'b0, 1'b0);
        dec_ctrl = 8'hA9;                       // decoder1 pin2, decoder0 pin1
        access(16'h0100, 1'b0, 1'b1, 1'b0);
        check("R9 not yet registered", {7'd0, fast_req}, 8'h00);
        @(posedge clk); #1;
        check("R9 fast after hit", {7'd0, fast_req}, 8'h01);
        access(16'h0200, 1'b0, 1'b1, 1'b0);
        @(posedge clk); #1;
        check("R9 no fast from slow decoder", {7'd0, fast_req}, 8'h00);
    endtask

    task automatic t_fast_all;
        fast_all = 1'b1;
        access(16'h0000, 1'b1, 1'b1, 1'b0);
        @(posedge clk); #1;
        check("R10 global fast", {7'd0, fast_req}, 8'h01);
        @(negedge clk); rst_n = 1'b0;
        @(posedge clk); #1;
        check("R11 reset clears fast", {7'd0, fast_req}, 8'h00);
        check("R11 selects ignore reset", pin_ovr, 8'h06);
        @(negedge clk); rst_n = 1'b1; fast_all = 1'b0;
    endtask

    initial begin
        t_reset();
        t_exact();
        t_mask();
        t_mirror();
        t_strobe();
        t_steer();
        t_disable();
        t_share();
        t_fast();
        t_fast_all();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        #800000;
        misses++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule